// File: doc/BRIEF.md
# Interrupt Vector Queue

This block buffers interrupt events raised inside a host-accessed terminal until the host collects them. Each event is a pair of bytes: an interrupt vector and an address vector. Internal sources present an event on a single push port. The queue keeps the events in arrival order and raises an interrupt request for as long as at least one event is waiting.

The host uses one register location for two things, told apart by direction. A read strobe pops the oldest event into two holding registers, the interrupt vector register and the address vector register. The read data word shows both bytes, with the address vector in the upper byte and the interrupt vector in the lower byte. A write strobe discards every queued event. The written value has no meaning, so the block takes no write data. A push that arrives while the queue is full is lost and sets a sticky overflow flag, which only a flush or a reset clears.

Reset is synchronous and active high. All outputs are registered.

Top module: `irq_vec_queue`

## Requirements
- R1: While reset is high and in the cycle after it, empty is 1 and full, irq, overflow and rd_data are all 0.
- R2: Events leave the queue in the order they were pushed. A read strobe sampled at a rising edge with the queue non-empty makes rd_data equal {address vector, interrupt vector} of the oldest event, with bits 15:8 holding the address vector and bits 7:0 holding the interrupt vector, from the cycle after that edge onward.
- R3: A read strobe while the queue is empty leaves rd_data, empty, full and overflow unchanged.
- R4: The queue holds 16 events. full is 1 exactly when 16 events are held, and empty is 1 exactly when none are held.
- R5: A push while the queue is full and no pop happens in the same cycle is dropped, and the stored events are unchanged. It sets overflow, which stays at 1 until a flush or a reset.
- R6: A push and a pop in the same cycle both take effect and leave the number of held events unchanged. This applies when the queue is full as well.
- R7: A write strobe empties the queue and clears overflow. It leaves rd_data unchanged.
- R8: When a write strobe coincides with a push or a read strobe, the flush takes priority: the push is dropped without setting overflow, and no pop occurs.
- R9: irq equals the inverse of empty in every cycle.
- R10: empty, full, irq and overflow reflect the effect of a strobe or push in the cycle right after the clock edge at which it was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | An internal source pushes an event this cycle |
| push_ivec | input | 8 | Interrupt vector of the pushed event |
| push_avec | input | 8 | Address vector of the pushed event |
| host_rd | input | 1 | Host read of the queue location (pop) |
| host_wr | input | 1 | Host write of the queue location (flush) |
| rd_data | output | 16 | {address vector register, interrupt vector register} |
| empty | output | 1 | No event is held |
| full | output | 1 | 16 events are held |
| overflow | output | 1 | Sticky: a push was lost because the queue was full |
| irq | output | 1 | Interrupt request, high while events are held |

## Verification
A wrong pointer or occupancy count appears at the ports as rd_data that breaks push order, or as empty or full changing at the wrong moment. Such an error shows on the next pop or on the flag update one cycle after the push or strobe that caused it. The bench keeps a reference queue and compares every output after every clock edge, so a divergence is reported in the cycle it first becomes visible. Directed runs cover the wraparound at 16 entries, a push and pop together while full, and a flush that coincides with other activity. In these cases a wrong priority or a wrong count otherwise stays hidden until a later pop.

// File: rtl/ivq_pkg.sv
package ivq_pkg;
  localparam int unsigned VEC_W = 8;

  // Upper field is the address vector, lower field the interrupt vector,
  // so the packed entry is already the host read word layout.
  typedef struct packed {
    logic [VEC_W-1:0] avec;
    logic [VEC_W-1:0] ivec;
  } ivq_entry_t;
endpackage

// File: rtl/ivq_store.sv
module ivq_store
  import ivq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  ivq_entry_t    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output ivq_entry_t    hold_q
);
  ivq_entry_t mem [DEPTH];
  ivq_entry_t hold_r;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // The synchronous read register doubles as the vector holding registers.
  always_ff @(posedge clk) begin
    if (rst)        hold_r <= '0;
    else if (rd_en) hold_r <= mem[rd_addr];
  end

  assign hold_q = hold_r;

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> hold_q == $past(hold_q));
endmodule

// File: rtl/ivq_ctrl.sv
module ivq_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          rd_req,
  input  logic          flush_req,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          empty_q,
  output logic          full_q,
  output logic          ovf_q,
  output logic          nxt_empty
);
  logic [AW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          pop_ok, push_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok  = rd_req && !flush_req && !empty_q;
  assign push_ok = push_req && !flush_req && (!full_q || pop_ok);

  always_comb begin
    if (flush_req) cnt_nxt = '0;
    else           cnt_nxt = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  assign nxt_empty = (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst || flush_req) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (pop_ok)  head_q <= ptr_inc(head_q);
      if (push_ok) tail_q <= ptr_inc(tail_q);
      cnt_q   <= cnt_nxt;
      empty_q <= nxt_empty;
      full_q  <= (cnt_nxt == CW'(DEPTH));
      if (push_req && !push_ok) ovf_q <= 1'b1;
    end
  end

  assign wr_en   = push_ok;
  assign wr_addr = tail_q;
  assign rd_en   = pop_ok;
  assign rd_addr = head_q;

  assert_flags_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(empty_q && full_q));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (full_q && push_req && !rd_req && !flush_req) |=> ovf_q && full_q);
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !flush_req) |=> ovf_q);
  assert_pushpop_count_R6: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> cnt_q == $past(cnt_q));
  assert_flush_R7: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> empty_q && !ovf_q && !full_q);
  assert_flush_wins_R8: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> !wr_en && !rd_en);
endmodule

// File: rtl/irq_vec_queue.sv
module irq_vec_queue
  import ivq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 push_valid,
  input  logic [VEC_W-1:0]     push_ivec,
  input  logic [VEC_W-1:0]     push_avec,
  input  logic                 host_rd,
  input  logic                 host_wr,
  output logic [2*VEC_W-1:0]   rd_data,
  output logic                 empty,
  output logic                 full,
  output logic                 overflow,
  output logic                 irq
);
  logic          wr_en, rd_en, nxt_empty;
  logic [AW-1:0] wr_addr, rd_addr;
  ivq_entry_t    wr_data, hold_q;
  logic          irq_q;

  assign wr_data.avec = push_avec;
  assign wr_data.ivec = push_ivec;

  ivq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .push_req(push_valid), .rd_req(host_rd), .flush_req(host_wr),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .empty_q(empty), .full_q(full), .ovf_q(overflow), .nxt_empty(nxt_empty)
  );

  ivq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .hold_q(hold_q)
  );

  always_ff @(posedge clk) begin
    if (rst || host_wr) irq_q <= 1'b0;
    else                irq_q <= !nxt_empty;
  end

  assign irq     = irq_q;
  assign rd_data = hold_q;

  assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (rst)
    irq == !empty);
  assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
    (host_rd && empty && !host_wr) |=> $stable(rd_data) && $stable(overflow));
  assert_flush_keeps_data_R7: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> $stable(rd_data));
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> empty && !full && !irq && !overflow && rd_data == '0);
endmodule

// File: tb/irq_vec_queue_test.sv
`timescale 1ns/1ps
module irq_vec_queue_test;
  localparam int DEPTH = 16;

  logic        clk = 0;
  logic        rst = 1;
  logic        push_valid = 0, host_rd = 0, host_wr = 0;
  logic [7:0]  push_ivec = 0, push_avec = 0;
  logic [15:0] rd_data;
  logic        empty, full, overflow, irq;

  int total = 0, bad = 0;
  string ctx = "R1";

  // reference model state
  logic [15:0] m_q [DEPTH];
  int          m_head = 0, m_cnt = 0;
  logic [15:0] m_rd = 0;
  bit          m_ovf = 0;

  always #2.5 clk = ~clk;

  irq_vec_queue #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_ivec(push_ivec),
    .push_avec(push_avec), .host_rd(host_rd), .host_wr(host_wr),
    .rd_data(rd_data), .empty(empty), .full(full), .overflow(overflow), .irq(irq)
  );

  task automatic check(input string field, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", ctx, field, act, exp);
    end
  endtask

  function automatic void model_update(input bit p, input logic [15:0] d, input bit r, input bit w);
    bit pop, pok;
    if (w) begin
      m_cnt = 0; m_head = 0; m_ovf = 0;
      return;
    end
    pop = r && (m_cnt > 0);
    pok = p && (m_cnt < DEPTH || pop);
    if (pop) begin
      m_rd = m_q[m_head];
      m_head = (m_head + 1) % DEPTH;
      m_cnt--;
    end
    if (pok) begin
      m_q[(m_head + m_cnt) % DEPTH] = d;
      m_cnt++;
    end else if (p) m_ovf = 1;
  endfunction

  // One clock: drive at negedge, compare every output just after the edge (R10 timing).
  task automatic step(input bit p, input logic [7:0] iv, input logic [7:0] av,
                      input bit r, input bit w);
    @(negedge clk);
    push_valid = p; push_ivec = iv; push_avec = av; host_rd = r; host_wr = w;
    @(posedge clk);
    #1;
    model_update(p, {av, iv}, r, w);
    check("rd_data R2", rd_data, m_rd);
    check("empty R4", 16'(empty), 16'(m_cnt == 0));
    check("full R4", 16'(full), 16'(m_cnt == DEPTH));
    check("overflow R5", 16'(overflow), 16'(m_ovf));
    check("irq R9", 16'(irq), 16'(m_cnt != 0));
    push_valid = 0; host_rd = 0; host_wr = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    ctx = "R1 reset";
    repeat (3) @(posedge clk);
    #1;
    check("empty", 16'(empty), 16'd1);
    check("full", 16'(full), 16'd0);
    check("irq", 16'(irq), 16'd0);
    check("overflow", 16'(overflow), 16'd0);
    check("rd_data", rd_data, 16'h0000);
    @(negedge clk); rst = 0;

    // R3: read of an empty queue changes nothing
    ctx = "R3 empty read";
    step(0, 0, 0, 1, 0);

    // R4 / R2: fill to 16, then drain in order
    ctx = "R4 fill";
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i + 8'h10), 8'(8'hA0 + i), 0, 0);
    check("full after 16", 16'(full), 16'd1);
    ctx = "R2 drain order";
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 0, 1, 0);
      check("popped word", rd_data, {8'(8'hA0 + i), 8'(i + 8'h10)});
    end
    ctx = "R3 read after drain";
    step(0, 0, 0, 1, 0);

    // R5: overflow on a full queue
    ctx = "R5 overflow";
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 8'h55, 0, 0);
    step(1, 8'hEE, 8'hEE, 0, 0);
    check("overflow set", 16'(overflow), 16'd1);
    step(0, 0, 0, 0, 0);
    check("overflow sticky", 16'(overflow), 16'd1);

    // R6: push and pop together while full
    ctx = "R6 push+pop full";
    step(1, 8'h77, 8'h66, 1, 0);
    check("oldest popped", rd_data, 16'h5500);
    check("still full", 16'(full), 16'd1);

    // R7: flush empties, clears overflow, keeps vectors
    ctx = "R7 flush";
    step(0, 0, 0, 0, 1);
    check("rd_data kept", rd_data, 16'h5500);
    check("overflow cleared", 16'(overflow), 16'd0);

    // R8: flush wins over push and read
    ctx = "R8 flush priority";
    step(1, 8'h01, 8'h02, 0, 0);
    step(1, 8'h03, 8'h04, 1, 1);
    check("empty after flush", 16'(empty), 16'd1);
    check("rd_data kept", rd_data, 16'h5500);

    // constrained random mix
    ctx = "R2/R6/R10 random";
    for (int n = 0; n < 4000; n++) begin
      bit p, r, w;
      p = ($urandom % 100) < 55;
      r = ($urandom % 100) < 45;
      w = ($urandom % 100) < 2;
      step(p, 8'($urandom), 8'($urandom), r, w);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule